// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block widens a 16-bit CPU address into a 24-bit physical address by paging. The CPU address space is cut into sixteen 4 KB pages. The top four address bits pick one of sixteen 12-bit page entries, and that entry takes the place of those four bits in the physical address. The twelve offset bits are never altered. The path from CPU address to physical address is purely combinational, so each bus cycle sees the translation for the table as it stands.

Software fills the page table over an 8-bit data bus. A table chip select opens the sixteen entries as byte registers, and a second chip select opens a one-bit control word. Each 12-bit entry occupies two byte slots. Address bit 0 chooses the low byte (0) or the upper nibble (1), and address bits 4:1 choose the entry. Both the entries and the control word can be read back. Mapping starts in the pass-through mode after reset.

The control word is held as a two-state mode machine. State `MODE_IDENT` is entered at reset. In this state the physical address is the CPU address with eight zero bits above it. Transition `IDENT->XLATE` fires on a control write with data bit 0 set. State `MODE_XLATE` uses the page table. Transition `XLATE->IDENT` fires on a control write with data bit 0 clear. Any other cycle keeps the current state.

Top module: `page_mapper`

## Requirements
- R1: In `MODE_XLATE`, phys_addr[23:12] equals the entry selected by cpu_addr[15:12], in the same cycle as the address is presented.
- R2: phys_addr[11:0] equals cpu_addr[11:0] in both modes.
- R3: In `MODE_IDENT`, phys_addr[23:16] is zero and phys_addr[15:0] equals cpu_addr.
- R4: A cycle with map_cs and cpu_we high writes the entry chosen by cpu_addr[4:1] at the clock edge. With cpu_addr[0]=0 it loads entry bits 7:0 from cpu_wdata[7:0]. With cpu_addr[0]=1 it loads entry bits 11:8 from cpu_wdata[3:0]. The other bits of that entry and all other entries are left as they were. The new value is used from the cycle after the edge.
- R5: With map_cs high and cpu_we low, cpu_rdata is entry bits 7:0 when cpu_addr[0]=0, and {4'h0, entry bits 11:8} when cpu_addr[0]=1. map_cs wins if ctrl_cs is also high.
- R6: A cycle with ctrl_cs and cpu_we high moves the mode at the edge: data bit 0 = 1 selects `MODE_XLATE` and 0 selects `MODE_IDENT`. Data bits 7:1 have no effect. No other cycle changes the mode.
- R7: With ctrl_cs high, map_cs low and cpu_we low, cpu_rdata is {7'b0, mode}, where `MODE_XLATE` reads as 1.
- R8: Reset puts the block in `MODE_IDENT` and clears all sixteen entries to zero.
- R9: With neither chip select high, cpu_rdata is zero, and a cycle with cpu_we high changes no entry and no mode.
- R10: cpu_addr[15:5] takes no part in selecting the register for reads and writes, so every such value reaches the same entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address: translated, and low bits select the register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| map_cs | input | 1 | Selects the page-table byte registers |
| ctrl_cs | input | 1 | Selects the control word |
| cpu_rdata | output | 8 | Register readback data |
| phys_addr | output | 24 | Translated physical address |

## Verification
The bench writes the low byte and the upper nibble of one entry separately. A design that merged the two lanes would wipe the neighbouring bits, and the readback and the translated page would both show it. It rewrites the control word with the other seven data bits set, then clear, to catch a design that decoded the whole byte or missed a transition. It also repeats table accesses with junk in the high address bits to catch an index taken from the wrong field. Write strobes with no chip select must leave both the table and the mode unchanged. Cycles with both selects high must return the entry and not the control word.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;
    typedef enum logic [0:0] {
        MODE_IDENT = 1'b0,
        MODE_XLATE = 1'b1
    } map_mode_e;
endpackage

// File: rtl/map_mode_ctrl.sv
module map_mode_ctrl
    import page_mapper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic xlate_en
);
    map_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_IDENT;
        else        state_q <= state_d;
    end

    // transitions IDENT->XLATE and XLATE->IDENT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_IDENT: if (ctrl_wr && ctrl_bit)  state_d = MODE_XLATE;
            MODE_XLATE: if (ctrl_wr && !ctrl_bit) state_d = MODE_IDENT;
            default:    state_d = MODE_IDENT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MODE_XLATE: xlate_en = 1'b1;
            default:    xlate_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/map_table.sv
module map_table #(
    parameter int IDX_W   = 4,
    parameter int ENTRY_W = 12,
    parameter int DATA_W  = 8,
    parameter int BSEL_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [BSEL_W-1:0]  acc_bsel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [IDX_W-1:0]   xl_idx,
    output logic [ENTRY_W-1:0] xl_entry,
    output logic [DATA_W-1:0]  rd_byte
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int LANES = (ENTRY_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W = LANES * DATA_W;

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PAD_W-1:0]   padded;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < ENTRY_W; i++) begin
                if ((i / DATA_W) == int'(acc_bsel))
                    mem[acc_idx][i] <= wdata[i % DATA_W];
            end
        end
    end

    assign xl_entry = mem[xl_idx];

    always_comb begin
        padded = '0;
        padded[ENTRY_W-1:0] = mem[acc_idx];
        rd_byte = padded[int'(acc_bsel)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
    parameter int CPU_AW  = 16,
    parameter int IDX_W   = 4,
    parameter int ENTRY_W = 12,
    parameter int PHYS_AW = CPU_AW - IDX_W + ENTRY_W
) (
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               xlate_en,
    output logic [PHYS_AW-1:0] phys_addr
);
    localparam int OFF_W = CPU_AW - IDX_W;

    always_comb begin
        if (xlate_en) phys_addr = {entry, cpu_addr[OFF_W-1:0]};
        else          phys_addr = {{(PHYS_AW-CPU_AW){1'b0}}, cpu_addr};
    end
endmodule

// File: rtl/page_mapper.sv
module page_mapper #(
    parameter int CPU_AW  = 16,
    parameter int IDX_W   = 4,
    parameter int ENTRY_W = 12,
    parameter int DATA_W  = 8,
    parameter int PHYS_AW = CPU_AW - IDX_W + ENTRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_we,
    input  logic               map_cs,
    input  logic               ctrl_cs,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic [PHYS_AW-1:0] phys_addr
);
    localparam int LANES  = (ENTRY_W + DATA_W - 1) / DATA_W;
    localparam int BSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic               xlate_en;
    logic [ENTRY_W-1:0] xl_entry;
    logic [DATA_W-1:0]  tbl_byte;

    map_mode_ctrl mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_cs && cpu_we),
        .ctrl_bit (cpu_wdata[0]),
        .xlate_en (xlate_en)
    );

    map_table #(
        .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .DATA_W(DATA_W), .BSEL_W(BSEL_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_cs && cpu_we),
        .acc_idx  (cpu_addr[BSEL_W +: IDX_W]),
        .acc_bsel (cpu_addr[BSEL_W-1:0]),
        .wdata    (cpu_wdata),
        .xl_idx   (cpu_addr[CPU_AW-1 -: IDX_W]),
        .xl_entry (xl_entry),
        .rd_byte  (tbl_byte)
    );

    addr_xlate #(
        .CPU_AW(CPU_AW), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .PHYS_AW(PHYS_AW)
    ) xlate_i (
        .cpu_addr  (cpu_addr),
        .entry     (xl_entry),
        .xlate_en  (xlate_en),
        .phys_addr (phys_addr)
    );

    always_comb begin
        cpu_rdata = '0;
        if (!cpu_we) begin
            if (map_cs)       cpu_rdata = tbl_byte;
            else if (ctrl_cs) cpu_rdata = {{(DATA_W-1){1'b0}}, xlate_en};
        end
    end
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
    parameter int CPU_AW  = 16,
    parameter int DATA_W  = 8,
    parameter int PHYS_AW = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic [DATA_W-1:0]  cpu_wdata,
    input logic               cpu_we,
    input logic               map_cs,
    input logic               ctrl_cs,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic [PHYS_AW-1:0] phys_addr,
    input logic               xlate_en
);
    localparam int OFF_W = 12;

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

    assert_identity_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_en |-> phys_addr == {{(PHYS_AW-CPU_AW){1'b0}}, cpu_addr});

    assert_mode_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cs && cpu_we && cpu_wdata[0]) |=> xlate_en);

    assert_mode_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cs && cpu_we && !cpu_wdata[0]) |=> !xlate_en);

    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_cs && cpu_we) |=> $stable(xlate_en));

    assert_nibble_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (map_cs && !cpu_we && cpu_addr[0]) |-> cpu_rdata[DATA_W-1:4] == '0);

    assert_ctrl_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cs && !map_cs && !cpu_we) |-> cpu_rdata == {{(DATA_W-1){1'b0}}, xlate_en});

    assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_cs && !map_cs) |-> cpu_rdata == '0);
endmodule

bind page_mapper page_mapper_chk #(
    .CPU_AW(CPU_AW), .DATA_W(DATA_W), .PHYS_AW(PHYS_AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .map_cs    (map_cs),
    .ctrl_cs   (ctrl_cs),
    .cpu_rdata (cpu_rdata),
    .phys_addr (phys_addr),
    .xlate_en  (xlate_en)
);

// File: tb/page_mapper_tb_top.sv
module page_mapper_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        map_cs = 1'b0;
    logic        ctrl_cs = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [23:0] phys_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [11:0] ref_ent [16];
    bit          ref_en;

    always #(PERIOD/2) clk = ~clk;

    page_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .map_cs(map_cs), .ctrl_cs(ctrl_cs),
        .cpu_rdata(cpu_rdata), .phys_addr(phys_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive, compare against the model, clock, update the model
    task automatic step(input logic [15:0] a, input logic [7:0] d, input bit we,
                        input bit mcs, input bit ccs, input string rtag);
        logic [23:0] exp_p;
        logic [7:0]  exp_r;
        int          idx;
        string       tag;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = we; map_cs = mcs; ctrl_cs = ccs;
        #1;
        idx = int'(a[4:1]);
        if (ref_en) exp_p = {ref_ent[a[15:12]], a[11:0]};
        else        exp_p = {8'h00, a};
        check(phys_addr == exp_p, ref_en ? "R1" : "R3", phys_addr, exp_p);
        check(phys_addr[11:0] == a[11:0], "R2", {12'h0, phys_addr[11:0]}, {12'h0, a[11:0]});
        exp_r = 8'h00;
        if (!we && mcs)      exp_r = a[0] ? {4'h0, ref_ent[idx][11:8]} : ref_ent[idx][7:0];
        else if (!we && ccs) exp_r = {7'b0, ref_en};
        tag = rtag;
        if (tag == "") tag = mcs ? "R5" : (ccs ? "R7" : "R9");
        check(cpu_rdata == exp_r, tag, {16'h0, cpu_rdata}, {16'h0, exp_r});
        @(posedge clk);
        if (we && mcs) begin
            if (a[0]) ref_ent[idx][11:8] = d[3:0];
            else      ref_ent[idx][7:0]  = d;
        end
        if (we && ccs) ref_en = d[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) ref_ent[k] = '0;
        ref_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8: reset state, every entry and the mode read back as zero
        step(16'h0000, 8'h00, 0, 0, 1, "R8");
        for (int k = 0; k < 32; k++) step(16'(k), 8'h00, 0, 1, 0, "R8");

        // R4 R10: fill table, high address bits carry junk
        for (int k = 0; k < 16; k++) begin
            step({11'(k * 97 + 3), 4'(k), 1'b0}, 8'((k * 37 + 5) & 255), 1, 1, 0, "R4");
            step({11'(k * 53 + 1), 4'(k), 1'b1}, 8'hF0 | 8'((k * 3 + 1) & 15), 1, 1, 0, "R4");
        end
        // R5 R10: readback through aliased addresses
        for (int k = 0; k < 32; k++) step({11'(k * 29 + 7), 5'(k)}, 8'h00, 0, 1, 0, "R10");

        // R3: pages while in identity mode
        for (int k = 0; k < 16; k++) step({4'(k), 12'(k * 251 + 9)}, 8'h00, 0, 0, 0, "R9");

        // R6 R7: enable with other data bits set
        step(16'h0000, 8'hFF, 1, 0, 1, "R6");
        step(16'h0000, 8'h00, 0, 0, 1, "R7");

        // R1 R2: every page translated
        for (int k = 0; k < 16; k++) step({4'(k), 12'(k * 401 + 17)}, 8'h00, 0, 0, 0, "R9");

        // R4: low byte only of entry 5, upper nibble kept, used next cycle
        step(16'h000A, 8'hC3, 1, 1, 0, "R4");
        step(16'h5123, 8'h00, 0, 0, 0, "R4");
        step(16'h000B, 8'h00, 0, 1, 0, "R4");
        // upper nibble only of entry 9
        step(16'h0013, 8'hA6, 1, 1, 0, "R4");
        step(16'h9FFF, 8'h00, 0, 0, 0, "R4");
        step(16'h0012, 8'h00, 0, 1, 0, "R4");

        // R9: write strobes with no chip select change nothing
        for (int k = 0; k < 8; k++) step(16'(k * 2), 8'h5A, 1, 0, 0, "R9");
        step(16'h0000, 8'h00, 0, 0, 1, "R9");
        for (int k = 0; k < 16; k++) step(16'(k), 8'h00, 0, 1, 0, "R9");

        // R5: both selects high, table wins
        step(16'h0006, 8'h00, 0, 1, 1, "R5");
        step(16'h0007, 8'h00, 0, 1, 1, "R5");

        // R6: disable with other data bits set, then identity again
        step(16'h0000, 8'hFE, 1, 0, 1, "R6");
        step(16'h0000, 8'h00, 0, 0, 1, "R7");
        for (int k = 0; k < 16; k++) step({4'(k), 12'(k * 77)}, 8'h00, 0, 0, 0, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule